// File: doc/BRIEF.md
# Sixteen-Bit Compare Timer with Forced Compare

This block is a 16-bit up-counter with two compare channels, A and B, programmed through an 8-bit register port. The counter advances on every system clock or on each rising edge of an external count pin. It runs either free, wrapping through zero, or in clear-on-match mode, where compare register A sets the top value. Each channel compares the counter against its own register. On a match it sets a sticky flag and applies a two-bit action to its waveform output.

Software can also strobe a forced compare on either channel. A forced compare applies the channel action at once. It does not set a flag and does not clear the counter. All 16-bit registers are moved through one shared 8-bit high-byte holding register, so each 16-bit value is read or written as a whole. A write to the counter suppresses compare matches on the following count tick.

Register map (address: content):
- 0 CTRL: [1:0] action A, [3:2] action B, [5:4] mode (00 free-running, 01 clear-on-match, 1x PWM-class), [6] source (0 clock, 1 external pin), [7] run.
- 1 FORCE: bit 7 forces A, bit 6 forces B.
- 2/3 counter low/high, 4/5 compare A low/high, 6/7 compare B low/high.
- 8 FLAGS: bit 0 A, bit 1 B.

Top module: `cmp_timer16`

## Requirements
- R1: After reset the counter, both compare registers, CTRL, FLAGS and both waveform outputs are zero.
- R2: Writing an odd (high) address stores the byte in the shared holding register. Writing the matching even (low) address commits {holding, data} to the 16-bit register. Reading a low address returns the low byte and copies that register's high byte into the holding register. Reading any high address returns the holding register, whichever register last filled it.
- R3: Reading FORCE always returns 0x00.
- R4: A one written to FORCE bit 7 (A) or bit 6 (B) applies that channel's action in the next cycle. The action codes are 00 = unchanged, 01 = toggle, 10 = drive low and 11 = drive high.
- R5: When the mode field is 10 or 11, writes to FORCE leave both waveform outputs unchanged.
- R6: A forced compare never sets a flag. It never clears or changes the counter, even in clear-on-match mode with the counter equal to compare A.
- R7: On a count tick where the counter equals a compare register, that channel's flag becomes 1 and its action is applied. Writing a 1 to a FLAGS bit clears that flag.
- R8: In free-running mode the counter steps from 0xFFFF to 0x0000.
- R9: In clear-on-match mode a tick with the counter equal to compare A loads zero, so a counter started at or below compare A never exceeds it.
- R10: After a counter write, the next count tick produces no match on either channel. The counter still advances on that tick.
- R11: With the source bit set, each rising edge on the external pin advances the counter by one, whatever else drives that pin. With the run bit clear, the counter does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_cnt_pin | input | 1 | External count input, synchronized inside |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while reg_rd is high |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |
| flag_a | output | 1 | Channel A match flag |
| flag_b | output | 1 | Channel B match flag |

## Verification
The hardest case to reach is a tick that lands on a counter value equal to compare A right after software wrote that value. With the clock as source, the counter races past before any bus check can be placed. The stimulus therefore switches to the external source and pulses the pin one edge at a time. It writes the counter to the compare value, gives one edge, and expects no flag. It then writes one below the compare value and gives two edges, so the second edge produces a real match.

// File: rtl/cmp_timer16_pkg.sv
// Package: shared widths, register addresses and action codes for the
// 16-bit compare timer. Assumes an 8-bit register port.
package cmp_timer16_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 4'd0,
        A_FORCE  = 4'd1,
        A_CNT_L  = 4'd2,
        A_CNT_H  = 4'd3,
        A_CMPA_L = 4'd4,
        A_CMPA_H = 4'd5,
        A_CMPB_L = 4'd6,
        A_CMPB_H = 4'd7,
        A_FLAGS  = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_LOW    = 2'b10,
        ACT_HIGH   = 2'b11
    } wave_act_e;

    localparam logic [1:0] MODE_FREE = 2'b00;
    localparam logic [1:0] MODE_CLR  = 2'b01;
endpackage

// File: rtl/cmp_timer16_tick.sv
// Tick generator: selects the system clock or synchronized rising edges of
// the external pin as the count tick, gated by run. Assumes the pin is
// asynchronous and slower than half the clock rate.
module cmp_timer16_tick #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic ext_sel,
    input  logic run,
    output logic tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            // Purpose: one synchronizer stage for the external pin.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else if (i == 0) sync_q[i] <= pin;
                else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    // Purpose: remember the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else prev_q <= sync_q[SYNC_STAGES-1];
    end

    // Purpose: pick the tick source and gate it with run.
    always_comb begin
        tick = run && (ext_sel ? (sync_q[SYNC_STAGES-1] && !prev_q) : 1'b1);
    end
endmodule

// File: rtl/cmp_timer16_regs.sv
// Register port: holds control and compare registers, the shared high-byte
// holding register, read data and force strobes. Assumes single-cycle
// write and read strobes that are not both high at once.
module cmp_timer16_regs
    import cmp_timer16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [1:0]        flags,
    output logic [1:0]        act_a,
    output logic [1:0]        act_b,
    output logic [1:0]        mode,
    output logic              ext_sel,
    output logic              run,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_b,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              force_a,
    output logic              force_b,
    output logic [1:0]        flag_clr
);
    localparam int HI_LSB = CNT_W - BYTE_W;

    logic [BYTE_W-1:0] ctrl_q;
    logic [BYTE_W-1:0] hold_q;
    logic              wr_ctrl, wr_force, wr_flags;
    logic              no_pwm;

    assign act_a   = ctrl_q[1:0];
    assign act_b   = ctrl_q[3:2];
    assign mode    = ctrl_q[5:4];
    assign ext_sel = ctrl_q[6];
    assign run     = ctrl_q[7];

    // Purpose: decode the write strobes.
    always_comb begin
        wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
        wr_force  = reg_wr && (reg_addr == A_FORCE);
        wr_flags  = reg_wr && (reg_addr == A_FLAGS);
        cnt_wr    = reg_wr && (reg_addr == A_CNT_L);
        cnt_wdata = {hold_q, reg_wdata};
        no_pwm    = !mode[1];
        force_a   = wr_force && reg_wdata[7] && no_pwm;
        force_b   = wr_force && reg_wdata[6] && no_pwm;
        flag_clr  = wr_flags ? reg_wdata[1:0] : 2'b00;
    end

    // Purpose: control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= reg_wdata;
    end

    // Purpose: compare registers, committed as whole words on a low-byte write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_a <= '0;
            cmp_b <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CMPA_L) cmp_a <= {hold_q, reg_wdata};
            if (reg_addr == A_CMPB_L) cmp_b <= {hold_q, reg_wdata};
        end
    end

    // Purpose: shared holding register, filled by high writes and low reads.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else if (reg_wr && reg_addr[0] && (reg_addr != A_FORCE) && (reg_addr <= A_CMPB_H))
            hold_q <= reg_wdata;
        else if (reg_rd) begin
            case (reg_addr)
                A_CNT_L:  hold_q <= cnt[CNT_W-1:HI_LSB];
                A_CMPA_L: hold_q <= cmp_a[CNT_W-1:HI_LSB];
                A_CMPB_L: hold_q <= cmp_b[CNT_W-1:HI_LSB];
                default:  hold_q <= hold_q;
            endcase
        end
    end

    // Purpose: read data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                A_CTRL:   reg_rdata = ctrl_q;
                A_CNT_L:  reg_rdata = cnt[BYTE_W-1:0];
                A_CMPA_L: reg_rdata = cmp_a[BYTE_W-1:0];
                A_CMPB_L: reg_rdata = cmp_b[BYTE_W-1:0];
                A_CNT_H, A_CMPA_H, A_CMPB_H: reg_rdata = hold_q;
                A_FLAGS:  reg_rdata = {{(BYTE_W-2){1'b0}}, flags};
                default:  reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cmp_timer16_core.sv
// Counter core: counts on tick, clears at compare A in clear-on-match
// mode, and reports per-channel hits. A counter write blocks hits until
// one tick has passed. Assumes a write wins over a coincident tick.
module cmp_timer16_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr_mode,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output logic [CNT_W-1:0] cnt,
    output logic             hit_a,
    output logic             hit_b
);
    logic blocked_q;
    logic live;

    // Purpose: a tick may produce hits only if no write is pending or present.
    always_comb begin
        live  = tick && !blocked_q && !cnt_wr;
        hit_a = live && (cnt == cmp_a);
        hit_b = live && (cnt == cmp_b);
    end

    // Purpose: counter and the one-tick match block after a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            blocked_q <= 1'b0;
        end else if (cnt_wr) begin
            cnt       <= cnt_wdata;
            blocked_q <= 1'b1;
        end else if (tick) begin
            blocked_q <= 1'b0;
            cnt       <= (clr_mode && hit_a) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cmp_timer16_chan.sv
// Compare channel: applies the two-bit action on a hit or a force and
// keeps a sticky match flag that only hits set. Assumes force arrives
// already gated by the mode.
module cmp_timer16_chan
    import cmp_timer16_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       force_cmp,
    input  logic [1:0] act,
    input  logic       clr,
    output logic       wave,
    output logic       flag
);
    // Purpose: waveform output update.
    always_ff @(posedge clk) begin
        if (!rst_n) wave <= 1'b0;
        else if (hit || force_cmp) begin
            case (wave_act_e'(act))
                ACT_TOGGLE: wave <= !wave;
                ACT_LOW:    wave <= 1'b0;
                ACT_HIGH:   wave <= 1'b1;
                default:    wave <= wave;
            endcase
        end
    end

    // Purpose: sticky flag, set by hits, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end
endmodule

// File: rtl/cmp_timer16.sv
// Top: 16-bit compare timer with forced compare. Wires the register port,
// tick generator, counter core and two compare channels.
module cmp_timer16
    import cmp_timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_cnt_pin,
    input  logic [3:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       wave_a,
    output logic       wave_b,
    output logic       flag_a,
    output logic       flag_b
);
    localparam int CNT_W = 2 * BYTE_W;

    logic [1:0]       act_a, act_b, mode, flag_clr;
    logic             ext_sel, run, tick, cnt_wr, force_a, force_b;
    logic             hit_a, hit_b, clr_mode;
    logic [CNT_W-1:0] cmp_a, cmp_b, cnt, cnt_wdata;

    assign clr_mode = (mode == MODE_CLR);

    cmp_timer16_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cnt(cnt), .flags({flag_b, flag_a}), .act_a(act_a), .act_b(act_b),
        .mode(mode), .ext_sel(ext_sel), .run(run), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .force_a(force_a), .force_b(force_b), .flag_clr(flag_clr)
    );

    cmp_timer16_tick #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk(clk), .rst_n(rst_n), .pin(ext_cnt_pin), .ext_sel(ext_sel),
        .run(run), .tick(tick)
    );

    cmp_timer16_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clr_mode(clr_mode),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_a(cmp_a),
        .cmp_b(cmp_b), .cnt(cnt), .hit_a(hit_a), .hit_b(hit_b)
    );

    cmp_timer16_chan u_chan_a (
        .clk(clk), .rst_n(rst_n), .hit(hit_a), .force_cmp(force_a),
        .act(act_a), .clr(flag_clr[0]), .wave(wave_a), .flag(flag_a)
    );

    cmp_timer16_chan u_chan_b (
        .clk(clk), .rst_n(rst_n), .hit(hit_b), .force_cmp(force_b),
        .act(act_b), .clr(flag_clr[1]), .wave(wave_b), .flag(flag_b)
    );
endmodule

// File: rtl/cmp_timer16_chk.sv
// Checker for cmp_timer16: temporal properties over ports and the signals
// passed between its sub-blocks. Attached by bind below.
module cmp_timer16_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_addr,
    input logic        reg_rd,
    input logic [7:0]  reg_rdata,
    input logic        wave_a,
    input logic        wave_b,
    input logic        flag_a,
    input logic        flag_b,
    input logic        tick,
    input logic        cnt_wr,
    input logic        clr_mode,
    input logic        hit_a,
    input logic        hit_b,
    input logic        force_a,
    input logic        force_b,
    input logic [15:0] cnt
);
    assert_force_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 4'd1) |-> (reg_rdata == 8'h00));

    assert_wave_a_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_a) |-> $past(hit_a || force_a));

    assert_wave_b_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wave_b) |-> $past(hit_b || force_b));

    assert_flag_a_from_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_a) |-> $past(hit_a));

    assert_flag_b_from_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_b) |-> $past(hit_b));

    assert_free_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !clr_mode) |=> (cnt == $past(cnt) + 16'd1));

    assert_clear_at_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_a && clr_mode) |=> (cnt == 16'd0));

    assert_write_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (!hit_a && !hit_b));
endmodule

bind cmp_timer16 cmp_timer16_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .wave_a(wave_a), .wave_b(wave_b),
    .flag_a(flag_a), .flag_b(flag_b), .tick(tick), .cnt_wr(cnt_wr),
    .clr_mode(clr_mode), .hit_a(hit_a), .hit_b(hit_b), .force_a(force_a),
    .force_b(force_b), .cnt(cnt)
);

// File: tb/tb_cmp_timer16.sv
module tb_cmp_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_cnt_pin = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       wave_a, wave_b, flag_a, flag_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cmp_timer16 dut (
        .clk(clk), .rst_n(rst_n), .ext_cnt_pin(ext_cnt_pin),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .wave_a(wave_a),
        .wave_b(wave_b), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
        wr(lo + 4'd1, v[15:8]);
        wr(lo, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
        logic [7:0] l, h;
        rd(lo, l);
        rd(lo + 4'd1, h);
        v = {h, l};
    endtask

    task automatic pulse();
        @(negedge clk); ext_cnt_pin = 1'b1;
        repeat (4) @(negedge clk);
        ext_cnt_pin = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] b; logic [15:0] v;
        rd(4'd0, b);  check(b == 8'h00, "R1 ctrl", b, 0);
        rd16(4'd2, v); check(v == 16'h0, "R1 counter", v, 0);
        rd16(4'd4, v); check(v == 16'h0, "R1 compare A", v, 0);
        rd(4'd8, b);  check(b == 8'h00, "R1 flags", b, 0);
        check({wave_a, wave_b} == 2'b00, "R1 waves", {wave_a, wave_b}, 0);
    endtask

    task automatic t_atomic();
        logic [7:0] b; logic [15:0] v;
        wr16(4'd6, 16'hBEEF);
        wr16(4'd2, 16'h1234);
        rd16(4'd2, v); check(v == 16'h1234, "R2 counter word", v, 16'h1234);
        rd16(4'd6, v); check(v == 16'hBEEF, "R2 compare B word", v, 16'hBEEF);
        rd(4'd2, b);
        rd(4'd5, b); check(b == 8'h12, "R2 shared holding", b, 8'h12);
        rd(4'd1, b); check(b == 8'h00, "R3 force reads zero", b, 0);
        wr(4'd1, 8'hFF);
        rd(4'd1, b); check(b == 8'h00, "R3 force after write", b, 0);
    endtask

    task automatic t_force();
        logic [7:0] b; logic [15:0] v;
        wr(4'd0, 8'h0D);
        wr(4'd1, 8'h80); check(wave_a == 1'b1, "R4 toggle A", wave_a, 1);
        wr(4'd1, 8'h40); check(wave_b == 1'b1, "R4 set B", wave_b, 1);
        wr(4'd0, 8'h09);
        wr(4'd1, 8'h40); check(wave_b == 1'b0, "R4 clear B", wave_b, 0);
        wr(4'd0, 8'h00);
        wr(4'd1, 8'hC0); check({wave_a, wave_b} == 2'b10, "R4 action none", {wave_a, wave_b}, 2);
        wr(4'd0, 8'h21);
        wr(4'd1, 8'h80); check(wave_a == 1'b1, "R5 PWM mode ignores force", wave_a, 1);
        wr(4'd0, 8'h11);
        wr16(4'd4, 16'h0007);
        wr16(4'd2, 16'h0007);
        wr(4'd1, 8'h80); check(wave_a == 1'b0, "R6 force acts in clear mode", wave_a, 0);
        rd(4'd8, b); check(b == 8'h00, "R6 no flag from force", b, 0);
        rd16(4'd2, v); check(v == 16'h0007, "R6 counter untouched", v, 7);
    endtask

    task automatic t_match();
        logic [7:0] b;
        wr16(4'd4, 16'h0005);
        wr16(4'd2, 16'h0000);
        wr(4'd0, 8'h81);
        repeat (20) @(negedge clk);
        wr(4'd0, 8'h01);
        check(flag_a == 1'b1, "R7 flag A on match", flag_a, 1);
        check(wave_a == 1'b1, "R7 toggle on match", wave_a, 1);
        check(flag_b == 1'b0, "R7 flag B quiet", flag_b, 0);
        wr(4'd8, 8'h01);
        rd(4'd8, b); check(b == 8'h00, "R7 write-one clears", b, 0);
    endtask

    task automatic t_clear_mode();
        logic [15:0] v;
        wr16(4'd4, 16'h0003);
        wr16(4'd2, 16'h0000);
        wr(4'd0, 8'h90);
        repeat (23) @(negedge clk);
        wr(4'd0, 8'h10);
        rd16(4'd2, v); check(v <= 16'h0003, "R9 counter bounded by top", v, 3);
        check(flag_a == 1'b1, "R9 match at top", flag_a, 1);
        wr(4'd8, 8'h03);
    endtask

    task automatic t_ext_wrap();
        logic [15:0] v;
        wr16(4'd4, 16'h0005);
        wr(4'd0, 8'h40);
        wr16(4'd2, 16'hFFFF);
        wr(4'd0, 8'hC0);
        pulse();
        rd16(4'd2, v); check(v == 16'h0000, "R8 wrap on external edge", v, 0);
        pulse();
        rd16(4'd2, v); check(v == 16'h0001, "R11 one edge one step", v, 1);
        wr(4'd0, 8'h40);
        pulse();
        rd16(4'd2, v); check(v == 16'h0001, "R11 run clear holds", v, 1);
    endtask

    task automatic t_block();
        logic [15:0] v;
        wr(4'd8, 8'h03);
        wr(4'd0, 8'hC0);
        wr16(4'd2, 16'h0005);
        pulse();
        rd16(4'd2, v); check(v == 16'h0006, "R10 blocked tick advances", v, 6);
        check(flag_a == 1'b0, "R10 no match after write", flag_a, 0);
        wr16(4'd2, 16'h0004);
        pulse();
        check(flag_a == 1'b0, "R10 consumed tick", flag_a, 0);
        pulse();
        check(flag_a == 1'b1, "R10 later match counts", flag_a, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_atomic();
        t_force();
        t_match();
        t_clear_mode();
        t_ext_wrap();
        t_block();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule